// File: doc/BRIEF.md
# Presettable Down Counter with Zero Flag

This block is an 8-bit binary counter that counts down. It can be loaded in three ways: cleared to full scale, loaded from a parallel word right away, or loaded from that word on the next clock edge. When no load is active and the enable input is low, the count drops by one on each rising clock edge. When the count reaches zero, the next counting edge wraps it back to full scale. With no loads applied, the block therefore divides the clock by 256. It can also serve as a programmable divider or timer, reloaded from its own zero flag.

All four controls are active low. Clear has the highest priority and acts at once. The asynchronous load comes next and also acts at once. The synchronous load comes third and works even while counting is disabled. The enable input also serves as a carry input, so several counters can be chained. The active-low zero flag depends only on the present count and the enable input. It goes low only while the count is zero and the enable is low, and it stays high at zero while the enable is high. The present count is brought out as a port so that it can be observed.

Top module: `preset_down_counter`

## Requirements
- R1: With all three load controls high and cen_n_i low, each rising clock edge lowers count_o by exactly one.
- R2: While clr_n_i is low, count_o shows 255 (all ones) at once, without waiting for a clock edge, and ignores every other input. The register keeps 255 after clr_n_i is released.
- R3: While aload_n_i is low and clr_n_i is high, count_o shows jam_i at once, whatever the clock, sload_n_i and cen_n_i are doing. The value is kept after release, provided jam_i is held stable while aload_n_i is low.
- R4: With clr_n_i and aload_n_i high and sload_n_i low, the next rising edge loads jam_i. This holds even when cen_n_i is high, and the load takes priority over a decrement.
- R5: With all loads inactive and cen_n_i high, clock edges leave count_o unchanged.
- R6: zero_n_o is low exactly when count_o equals 0 and cen_n_i is low. At zero, a high cen_n_i keeps the flag high. During free counting the flag is low for one clock period only.
- R7: A counting edge with count_o at 0 gives 255, so 256 counting edges bring the count back to its starting value.
- R8: zero_n_o is high whenever count_o is nonzero, including a count forced by the asynchronous load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting clock, rising edge active |
| clr_n_i | input | 1 | Asynchronous clear to full scale, active low, highest priority |
| aload_n_i | input | 1 | Asynchronous parallel load of jam_i, active low |
| sload_n_i | input | 1 | Synchronous parallel load of jam_i, active low |
| cen_n_i | input | 1 | Count enable / carry input, active low |
| jam_i | input | 8 | Parallel load word |
| zero_n_o | output | 1 | Zero detect / carry output, active low |
| count_o | output | 8 | Present count |

## Verification
Two functions can act on the same clock edge. In one case the synchronous load and the decrement fall together: sload_n_i and cen_n_i are both driven low for one edge, and the count must equal the jam word rather than the decremented value. In the other case the asynchronous controls collide with a pending load or count: clear and the asynchronous load are asserted together in mid-cycle while sload_n_i and cen_n_i are also low. The port must show full scale before any edge arrives, and the count after release must match a bench model that treats both asynchronous controls as acting outside the clock.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    localparam int unsigned PDC_W = 8;

    typedef enum logic [2:0] {
        MODE_CLEAR = 3'd0,
        MODE_ALOAD = 3'd1,
        MODE_SLOAD = 3'd2,
        MODE_COUNT = 3'd3,
        MODE_HOLD  = 3'd4
    } pdc_mode_e;

    // Resolve the four active-low controls into one operating mode, highest priority first.
    function automatic pdc_mode_e pdc_decode(input logic clr_n,
                                             input logic aload_n,
                                             input logic sload_n,
                                             input logic cen_n);
        pdc_mode_e m;
        if (!clr_n)        m = MODE_CLEAR;
        else if (!aload_n) m = MODE_ALOAD;
        else if (!sload_n) m = MODE_SLOAD;
        else if (!cen_n)   m = MODE_COUNT;
        else               m = MODE_HOLD;
        return m;
    endfunction

endpackage

// File: rtl/pdc_mode.sv
module pdc_mode
    import pdc_pkg::*;
(
    input  logic      clr_n_i,
    input  logic      aload_n_i,
    input  logic      sload_n_i,
    input  logic      cen_n_i,
    output pdc_mode_e mode_o
);
    always_comb begin
        mode_o = pdc_decode(clr_n_i, aload_n_i, sload_n_i, cen_n_i);
    end
endmodule

// File: rtl/pdc_step.sv
module pdc_step
    import pdc_pkg::*;
#(
    parameter int unsigned W = PDC_W
) (
    input  pdc_mode_e      mode_i,
    input  logic [W-1:0]   q_i,
    input  logic [W-1:0]   jam_i,
    output logic [W-1:0]   next_o,
    output logic [W-1:0]   shown_o
);
    localparam logic [W-1:0] FULL = {W{1'b1}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    // Value taken at the next rising edge when no asynchronous control is active.
    always_comb begin
        unique case (mode_i)
            MODE_SLOAD: next_o = jam_i;
            MODE_COUNT: next_o = q_i - ONE;
            default:    next_o = q_i;
        endcase
    end

    // Value seen at the port: asynchronous overrides show through at once.
    always_comb begin
        unique case (mode_i)
            MODE_CLEAR: shown_o = FULL;
            MODE_ALOAD: shown_o = jam_i;
            default:    shown_o = q_i;
        endcase
    end
endmodule

// File: rtl/pdc_zero.sv
module pdc_zero #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] cnt_i,
    input  logic         cen_n_i,
    output logic         zero_n_o
);
    always_comb begin
        zero_n_o = (|cnt_i) | cen_n_i;
    end
endmodule

// File: rtl/preset_down_counter.sv
module preset_down_counter
    import pdc_pkg::*;
#(
    parameter int unsigned W = PDC_W
) (
    input  logic         clk_i,
    input  logic         clr_n_i,
    input  logic         aload_n_i,
    input  logic         sload_n_i,
    input  logic         cen_n_i,
    input  logic [W-1:0] jam_i,
    output logic         zero_n_o,
    output logic [W-1:0] count_o
);
    localparam logic [W-1:0] FULL = {W{1'b1}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    pdc_mode_e    mode;
    logic [W-1:0] q_r;
    logic [W-1:0] q_next;
    logic [W-1:0] shown;

    pdc_mode u_mode (
        .clr_n_i   (clr_n_i),
        .aload_n_i (aload_n_i),
        .sload_n_i (sload_n_i),
        .cen_n_i   (cen_n_i),
        .mode_o    (mode)
    );

    pdc_step #(.W(W)) u_step (
        .mode_i  (mode),
        .q_i     (q_r),
        .jam_i   (jam_i),
        .next_o  (q_next),
        .shown_o (shown)
    );

    pdc_zero #(.W(W)) u_zero (
        .cnt_i    (shown),
        .cen_n_i  (cen_n_i),
        .zero_n_o (zero_n_o)
    );

    // Count register with asynchronous load; clear outranks the parallel load.
    always_ff @(posedge clk_i or negedge clr_n_i or negedge aload_n_i) begin
        if (!clr_n_i)        q_r <= FULL;
        else if (!aload_n_i) q_r <= jam_i;
        else                 q_r <= q_next;
    end

    assign count_o = shown;

    // Marks a clock interval touched by an asynchronous control, so that edge-to-edge checks skip it.
    logic async_seen;
    always_ff @(posedge clk_i or negedge clr_n_i or negedge aload_n_i) begin
        if (!clr_n_i)        async_seen <= 1'b1;
        else if (!aload_n_i) async_seen <= 1'b1;
        else                 async_seen <= 1'b0;
    end

    AST_COUNT_DOWN: assert property (@(posedge clk_i)
        disable iff (!clr_n_i || !aload_n_i || async_seen)
        (sload_n_i && !cen_n_i) |=> (count_o == $past(count_o) - ONE)); // R1

    AST_SYNC_LOAD: assert property (@(posedge clk_i)
        disable iff (!clr_n_i || !aload_n_i || async_seen)
        (!sload_n_i) |=> (count_o == $past(jam_i))); // R4

    AST_HOLD_STILL: assert property (@(posedge clk_i)
        disable iff (!clr_n_i || !aload_n_i || async_seen)
        (sload_n_i && cen_n_i) |=> $stable(count_o)); // R5

    AST_ZERO_WRAP: assert property (@(posedge clk_i)
        disable iff (!clr_n_i || !aload_n_i || async_seen)
        (sload_n_i && !cen_n_i && count_o == '0) |=> (count_o == FULL)); // R7

    AST_ZERO_ONE_CYCLE: assert property (@(posedge clk_i)
        disable iff (!clr_n_i || !aload_n_i || async_seen)
        (!zero_n_o && sload_n_i) |=> zero_n_o); // R6

endmodule

// File: tb/test_preset_down_counter.sv
module test_preset_down_counter;

    logic       clk = 1'b0;
    logic       clr_n;
    logic       aload_n;
    logic       sload_n;
    logic       cen_n;
    logic [7:0] jam;
    logic       zero_n;
    logic [7:0] count;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [7:0] mdl;
    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    preset_down_counter i_preset_down_counter (
        .clk_i     (clk),
        .clr_n_i   (clr_n),
        .aload_n_i (aload_n),
        .sload_n_i (sload_n),
        .cen_n_i   (cen_n),
        .jam_i     (jam),
        .zero_n_o  (zero_n),
        .count_o   (count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Driver: set the inputs for the next edge and push the predicted result.
    task automatic drive(input logic sl, input logic ce, input logic [7:0] j, input string tag);
        logic zexp;
        @(negedge clk);
        sload_n = sl;
        cen_n   = ce;
        jam     = j;
        if (!sl)      mdl = j;
        else if (!ce) mdl = mdl - 8'd1;
        zexp = !((mdl == 8'd0) && !ce);
        exp_q.push_back({zexp, mdl});
        tag_q.push_back(tag);
    endtask

    // Monitor: mid-cycle after each edge, compare against the oldest prediction.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [8:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(count == e[7:0], {t, " count"}, count, e[7:0]);
                chk(zero_n == e[8], {t, " R8 zero flag"}, zero_n, e[8]);
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        clr_n = 1'b0; aload_n = 1'b1; sload_n = 1'b1; cen_n = 1'b1; jam = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        chk(count == 8'hFF, "R2 reset count", count, 255);
        chk(zero_n == 1'b1, "R2 reset flag", zero_n, 1);
        @(negedge clk);
        clr_n = 1'b1;
        mdl = 8'hFF;

        repeat (3) drive(1'b1, 1'b0, 8'h00, "R1 decrement");
        repeat (2) drive(1'b1, 1'b1, 8'h77, "R5 hold");
        drive(1'b0, 1'b1, 8'h03, "R4 load while disabled");
        repeat (3) drive(1'b1, 1'b0, 8'h00, "R6 count to zero");
        drive(1'b1, 1'b1, 8'h00, "R6 zero masked");
        drive(1'b1, 1'b0, 8'h00, "R7 wrap");
        drive(1'b0, 1'b0, 8'h10, "R4 load beats count");
        drive(1'b0, 1'b1, 8'h00, "R6 load zero masked");
        for (int i = 0; i < 256; i++) drive(1'b1, 1'b0, 8'h00, "R7 free run");
        repeat (3) @(posedge clk);
        chk(exp_q.size() == 0, "R7 drain", exp_q.size(), 0);

        // Asynchronous clear in mid-cycle, with a sync load and count pending.
        @(negedge clk);
        jam = 8'h21; sload_n = 1'b0; cen_n = 1'b0;
        clr_n = 1'b0;
        #1;
        chk(count == 8'hFF, "R2 async clear", count, 255);
        sload_n = 1'b1; cen_n = 1'b1;
        #1 clr_n = 1'b1;
        mdl = 8'hFF;
        @(posedge clk); #2;
        chk(count == 8'hFF, "R2 kept after release", count, 255);

        // Asynchronous load with counting enabled, no clock edge.
        @(negedge clk);
        cen_n = 1'b0; jam = 8'h5A;
        aload_n = 1'b0;
        #1;
        chk(count == 8'h5A, "R3 async load", count, 8'h5A);
        chk(zero_n == 1'b1, "R8 nonzero forced", zero_n, 1);
        cen_n = 1'b1;
        #1 aload_n = 1'b1;
        mdl = 8'h5A;
        drive(1'b1, 1'b0, 8'h00, "R3 count after load");

        // Asynchronous load of zero with enable low raises the flag at once.
        @(negedge clk);
        jam = 8'h00; cen_n = 1'b0;
        aload_n = 1'b0;
        #1;
        chk(zero_n == 1'b0, "R6 flag on forced zero", zero_n, 0);
        cen_n = 1'b1;
        #1 aload_n = 1'b1;
        mdl = 8'h00;

        // Clear and asynchronous load together: clear wins.
        @(negedge clk);
        jam = 8'h33; sload_n = 1'b0; cen_n = 1'b0;
        clr_n = 1'b0;
        #1 aload_n = 1'b0;
        #1;
        chk(count == 8'hFF, "R2 clear beats async load", count, 255);
        sload_n = 1'b1; cen_n = 1'b1;
        aload_n = 1'b1;
        #1 clr_n = 1'b1;
        mdl = 8'hFF;
        drive(1'b1, 1'b0, 8'h00, "R1 after clear");

        repeat (3) @(posedge clk);
        #1;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule